// File: doc/BRIEF.md
# Debug Register Front End with Challenge Unlock

This block is the register side of a single-hart debug unit. A debug transport presents one request per cycle: a valid strobe, a write flag, a 7-bit register address and a 32-bit write word. Reads are combinational from the address, and writes commit at the next rising clock edge. The block holds a run-control register, a status word, a transfer data word handed to an external command engine, and a challenge/response register. Until the correct response has been written, the block refuses almost every write.

The hart talks back through a small mailbox. Each store names one event: halted, going, resuming or exception. The mailbox moves the go flag, the resume flag, resume-acknowledge, the halted flag, the abstract-busy bit and a sticky exception flag. An external command engine raises `abs_start` when it launches a command, which sets both go and busy. Abstract command execution and system-bus access themselves are outside this block.

Top module: `dbg_regfront`

Register addresses: transfer data 0x04, run control 0x10, status 0x11 (read only), challenge 0x30. Unmapped addresses read as zero.

Run-control bits:

| Bit | Meaning |
| --- | --- |
| 0 | active |
| 1 | halt request |
| 2 | resume request |
| 3 | hart reset |
| 4 | system reset |
| 5 | acknowledge reset (write only, reads 0) |
| 6 | clear exception (write only, reads 0) |
| 8 and up | hart select, HSEL_W bits wide |

Status bits:

| Bit | Meaning |
| --- | --- |
| 0 | authenticated |
| 1 | implicit breakpoint (always 1) |
| 2 / 3 | all / any halted |
| 4 / 5 | all / any running |
| 6 / 7 | all / any nonexistent |
| 8 / 9 | all / any resume-acknowledged |
| 10 / 11 | all / any have-reset |
| 12 | busy |
| 13 | go flag |
| 14 | resume flag |
| 15 | exception |

Mailbox kind codes: 0 is halted, 1 is going, 2 is resuming, 3 is exception.

## Requirements
- R1: After reset, run control reads 0 and status reads 0x32 (running, implicit breakpoint, not authenticated). The challenge register reads the LFSR seed.
- R2: While not authenticated, a transfer-data write is ignored. A run-control write updates only the active bit (bit 0).
- R3: Writing challenge+SECRET to address 0x30 sets authenticated (status bit 0). Any other value clears authenticated and advances the challenge to a new value.
- R4: With AUTH_EN=0, status bit 0 reads 1 straight out of reset.
- R5: The halt request, resume request, hart reset, system reset and hart select fields change only on a run-control write whose bit 0 is 1. The active bit always takes bit 0 of the write.
- R6: A resume request (bit 2 in an accepted write) sets the resume flag (status bit 14) and clears resume-acknowledge. A resuming store (kind 2) sets resume-acknowledge (status bits 8 and 9), clears the resume flag, and marks the hart running.
- R7: A halted store (kind 0) sets halted (status bits 2 and 3). It also clears busy (status bit 12), but only if the go flag is already clear.
- R8: A going store (kind 1) clears the go flag (status bit 13). `abs_start` sets both go and busy.
- R9: An accepted write with bit 3 set raises have-reset in both status bits 10 and 11. An accepted write with bit 5 set clears it.
- R10: With hart 0 selected, exactly one of the halted pair (bits 2 and 3) and the running pair (bits 4 and 5) is set, and each "any" bit equals its "all" bit.
- R11: Selecting a nonzero hart index sets status bits 6 and 7. It clears the halted, running and resume-acknowledge bits.
- R12: An exception store (kind 3) sets status bit 15. It stays set until an accepted run-control write with bit 6 set.
- R13: A transfer-data write while busy is ignored. Once authenticated and not busy, a write to it is stored and drives `xfer_data`.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transport request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Register address |
| req_wdata | input | 32 | Write word |
| rd_data | output | 32 | Read word for req_addr (combinational) |
| hart_st_valid | input | 1 | Hart mailbox store strobe |
| hart_st_kind | input | 2 | Mailbox event kind |
| abs_start | input | 1 | Command engine launched a command |
| abs_busy | output | 1 | Abstract command in flight |
| go_flag | output | 1 | Go flag seen by the hart |
| resume_flag | output | 1 | Resume flag seen by the hart |
| halt_req | output | 1 | Halt request to the hart |
| hart_reset | output | 1 | Hart reset request |
| sys_reset | output | 1 | System reset request |
| dm_active | output | 1 | Debug unit active |
| xfer_data | output | 32 | Transfer data word |
| hart_sel | output | HSEL_W | Selected hart index |

## Verification
On every cycle, the bound checker enforces four things:
- Writes are locked while unauthenticated or busy.
- Control fields hold when a write has bit 0 clear.
- The mailbox effects of resuming, going and halted stores land one cycle later.
- The have-reset pair and the halted/running pair stay consistent.

Other behaviour can only be shown by the bench's scenarios: the challenge changing after a failed response, the correct response unlocking the block, the configuration without authentication, the nonexistent-hart report, and the sticky exception clear.

// File: rtl/dbgfe_pkg.sv
package dbgfe_pkg;
   localparam logic [6:0] A_XDATA = 7'h04;
   localparam logic [6:0] A_CTRL  = 7'h10;
   localparam logic [6:0] A_STAT  = 7'h11;
   localparam logic [6:0] A_AUTH  = 7'h30;

   localparam int C_ACT  = 0;
   localparam int C_HALT = 1;
   localparam int C_RES  = 2;
   localparam int C_HRST = 3;
   localparam int C_SRST = 4;
   localparam int C_ACK  = 5;
   localparam int C_XCLR = 6;
   localparam int C_HSEL = 8;

   localparam int S_AUTH = 0;
   localparam int S_IMPE = 1;
   localparam int S_ALLH = 2;
   localparam int S_ANYH = 3;
   localparam int S_ALLR = 4;
   localparam int S_ANYR = 5;
   localparam int S_ALLN = 6;
   localparam int S_ANYN = 7;
   localparam int S_ALLA = 8;
   localparam int S_ANYA = 9;
   localparam int S_ALLX = 10;
   localparam int S_ANYX = 11;
   localparam int S_BUSY = 12;
   localparam int S_GO   = 13;
   localparam int S_RESF = 14;
   localparam int S_EXC  = 15;

   typedef enum logic [1:0] {
      HS_HALTED   = 2'd0,
      HS_GOING    = 2'd1,
      HS_RESUMING = 2'd2,
      HS_EXCEPT   = 2'd3
   } hstore_e;

   localparam logic [31:0] LFSR_TAPS = 32'hA300_0000;

   function automatic logic [31:0] lfsr_next(input logic [31:0] s);
      return {1'b0, s[31:1]} ^ (s[0] ? LFSR_TAPS : 32'h0);
   endfunction
endpackage

// File: rtl/dbgfe_auth.sv
module dbgfe_auth #(
   parameter bit          AUTH_EN   = 1'b1,
   parameter logic [31:0] SECRET    = 32'h5EC2_7A11,
   parameter logic [31:0] LFSR_SEED = 32'hACE1_0001
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        auth_wr,
   input  logic [31:0] auth_val,
   output logic        authed_o,
   output logic [31:0] chal_o
);
   import dbgfe_pkg::*;

   generate
      if (AUTH_EN) begin : g_lock
         logic [31:0] chal_q;
         logic        ok_q;
         logic        match;
         assign match = (auth_val == (chal_q + SECRET));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chal_q <= LFSR_SEED;
               ok_q   <= 1'b0;
            end else if (auth_wr) begin
               ok_q <= match;
               if (!match) chal_q <= lfsr_next(chal_q);
            end
         end
         assign authed_o = ok_q;
         assign chal_o   = chal_q;
      end else begin : g_open
         logic unused_auth;
         assign unused_auth = ^{auth_wr, auth_val, clk, rst_n};
         assign authed_o = 1'b1;
         assign chal_o   = 32'h0;
      end
   endgenerate
endmodule

// File: rtl/dbgfe_ctrl.sv
module dbgfe_ctrl #(
   parameter int HSEL_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              authed,
   input  logic              w_act,
   input  logic              w_halt,
   input  logic              w_res,
   input  logic              w_hrst,
   input  logic              w_srst,
   input  logic              w_ack,
   input  logic [HSEL_W-1:0] w_hsel,
   output logic              accept,
   output logic              active,
   output logic              halt,
   output logic              resreq,
   output logic              hrst,
   output logic              srst,
   output logic [HSEL_W-1:0] hsel,
   output logic              havereset
);
   assign accept = wr && authed && w_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         halt      <= 1'b0;
         resreq    <= 1'b0;
         hrst      <= 1'b0;
         srst      <= 1'b0;
         hsel      <= '0;
         havereset <= 1'b0;
      end else begin
         if (wr) active <= w_act;
         if (accept) begin
            halt   <= w_halt;
            resreq <= w_res;
            hrst   <= w_hrst;
            srst   <= w_srst;
            hsel   <= w_hsel;
            if (w_hrst)     havereset <= 1'b1;
            else if (w_ack) havereset <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dbgfe_mbox.sv
module dbgfe_mbox (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       st_valid,
   input  logic [1:0] st_kind,
   input  logic       abs_start,
   input  logic       resume_evt,
   input  logic       xclr_evt,
   output logic       halted,
   output logic       go,
   output logic       res_flag,
   output logic       res_ack,
   output logic       busy,
   output logic       exc
);
   import dbgfe_pkg::*;

   hstore_e kind;
   assign kind = hstore_e'(st_kind);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted   <= 1'b0;
         go       <= 1'b0;
         res_flag <= 1'b0;
         res_ack  <= 1'b0;
         busy     <= 1'b0;
         exc      <= 1'b0;
      end else begin
         if (st_valid) begin
            unique case (kind)
               HS_HALTED: begin
                  halted <= 1'b1;
                  if (!go) busy <= 1'b0;
               end
               HS_GOING:  go <= 1'b0;
               HS_RESUMING: begin
                  halted   <= 1'b0;
                  res_ack  <= 1'b1;
                  res_flag <= 1'b0;
               end
               HS_EXCEPT: exc <= 1'b1;
               default: ;
            endcase
         end
         if (resume_evt) begin
            res_flag <= 1'b1;
            res_ack  <= 1'b0;
         end
         if (xclr_evt) exc <= 1'b0;
         if (abs_start) begin
            go   <= 1'b1;
            busy <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/dbg_regfront.sv
module dbg_regfront #(
   parameter int          HSEL_W    = 4,
   parameter bit          AUTH_EN   = 1'b1,
   parameter logic [31:0] SECRET    = 32'h5EC2_7A11,
   parameter logic [31:0] LFSR_SEED = 32'hACE1_0001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [6:0]        req_addr,
   input  logic [31:0]       req_wdata,
   output logic [31:0]       rd_data,
   input  logic              hart_st_valid,
   input  logic [1:0]        hart_st_kind,
   input  logic              abs_start,
   output logic              abs_busy,
   output logic              go_flag,
   output logic              resume_flag,
   output logic              halt_req,
   output logic              hart_reset,
   output logic              sys_reset,
   output logic              dm_active,
   output logic [31:0]       xfer_data,
   output logic [HSEL_W-1:0] hart_sel
);
   import dbgfe_pkg::*;

   localparam int HSEL_TOP = C_HSEL + HSEL_W;

   generate
      if (HSEL_W < 1 || HSEL_TOP > 32) begin : g_bad_hsel
         $error("dbg_regfront: HSEL_W out of range");
      end
      if (AUTH_EN && LFSR_SEED == 32'h0) begin : g_bad_seed
         $error("dbg_regfront: LFSR_SEED must be nonzero");
      end
   endgenerate

   logic        wr_any, wr_ctrl, wr_data, wr_auth;
   logic        auth_ok, ctrl_acc;
   logic [31:0] chal;
   logic        halted_f, res_ack, exc_f, res_req_q, havereset;
   logic        hart_ok, resume_evt, xclr_evt;
   logic [31:0] stat_w, ctrl_w, xdata_q;

   assign wr_any  = req_valid && req_write;
   assign wr_ctrl = wr_any && (req_addr == A_CTRL);
   assign wr_auth = wr_any && (req_addr == A_AUTH);
   assign wr_data = wr_any && (req_addr == A_XDATA) && auth_ok && !abs_busy;

   dbgfe_auth #(
      .AUTH_EN(AUTH_EN), .SECRET(SECRET), .LFSR_SEED(LFSR_SEED)
   ) u_auth (
      .clk(clk), .rst_n(rst_n), .auth_wr(wr_auth), .auth_val(req_wdata),
      .authed_o(auth_ok), .chal_o(chal)
   );

   dbgfe_ctrl #(.HSEL_W(HSEL_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr(wr_ctrl), .authed(auth_ok),
      .w_act(req_wdata[C_ACT]), .w_halt(req_wdata[C_HALT]),
      .w_res(req_wdata[C_RES]), .w_hrst(req_wdata[C_HRST]),
      .w_srst(req_wdata[C_SRST]), .w_ack(req_wdata[C_ACK]),
      .w_hsel(req_wdata[C_HSEL +: HSEL_W]),
      .accept(ctrl_acc), .active(dm_active), .halt(halt_req),
      .resreq(res_req_q), .hrst(hart_reset), .srst(sys_reset),
      .hsel(hart_sel), .havereset(havereset)
   );

   assign resume_evt = ctrl_acc && req_wdata[C_RES] &&
                       (req_wdata[C_HSEL +: HSEL_W] == '0);
   assign xclr_evt   = ctrl_acc && req_wdata[C_XCLR];

   dbgfe_mbox u_mbox (
      .clk(clk), .rst_n(rst_n), .st_valid(hart_st_valid), .st_kind(hart_st_kind),
      .abs_start(abs_start), .resume_evt(resume_evt), .xclr_evt(xclr_evt),
      .halted(halted_f), .go(go_flag), .res_flag(resume_flag),
      .res_ack(res_ack), .busy(abs_busy), .exc(exc_f)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       xdata_q <= 32'h0;
      else if (wr_data) xdata_q <= req_wdata;
   end
   assign xfer_data = xdata_q;

   assign hart_ok = (hart_sel == '0);

   always_comb begin
      stat_w         = 32'h0;
      stat_w[S_AUTH] = auth_ok;
      stat_w[S_IMPE] = 1'b1;
      stat_w[S_ALLH] = hart_ok && halted_f;
      stat_w[S_ANYH] = hart_ok && halted_f;
      stat_w[S_ALLR] = hart_ok && !halted_f;
      stat_w[S_ANYR] = hart_ok && !halted_f;
      stat_w[S_ALLN] = !hart_ok;
      stat_w[S_ANYN] = !hart_ok;
      stat_w[S_ALLA] = hart_ok && res_ack;
      stat_w[S_ANYA] = hart_ok && res_ack;
      stat_w[S_ALLX] = havereset;
      stat_w[S_ANYX] = havereset;
      stat_w[S_BUSY] = abs_busy;
      stat_w[S_GO]   = go_flag;
      stat_w[S_RESF] = resume_flag;
      stat_w[S_EXC]  = exc_f;
   end

   always_comb begin
      ctrl_w                       = 32'h0;
      ctrl_w[C_ACT]                = dm_active;
      ctrl_w[C_HALT]               = halt_req;
      ctrl_w[C_RES]                = res_req_q;
      ctrl_w[C_HRST]               = hart_reset;
      ctrl_w[C_SRST]               = sys_reset;
      ctrl_w[C_HSEL +: HSEL_W]     = hart_sel;
   end

   always_comb begin
      unique case (req_addr)
         A_XDATA: rd_data = xdata_q;
         A_CTRL:  rd_data = ctrl_w;
         A_STAT:  rd_data = stat_w;
         A_AUTH:  rd_data = chal;
         default: rd_data = 32'h0;
      endcase
   end
endmodule

// File: rtl/dbgfe_chk.sv
module dbgfe_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_write,
   input logic [6:0]  req_addr,
   input logic [31:0] req_wdata,
   input logic        hart_st_valid,
   input logic [1:0]  hart_st_kind,
   input logic        abs_start,
   input logic        abs_busy,
   input logic        go_flag,
   input logic        resume_flag,
   input logic        halt_req,
   input logic [31:0] xfer_data,
   input logic        authed,
   input logic        res_ack,
   input logic [31:0] stat_word
);
   import dbgfe_pkg::*;

   logic wr_x, wr_c;
   assign wr_x = req_valid && req_write && (req_addr == A_XDATA);
   assign wr_c = req_valid && req_write && (req_addr == A_CTRL);

   // R2
   auth_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_x && !authed) |=> $stable(xfer_data));

   // R13
   busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_x && abs_busy) |=> $stable(xfer_data));

   // R5
   inactive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_c && !req_wdata[C_ACT]) |=> $stable(halt_req));

   // R6
   resume_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hart_st_valid && hart_st_kind == HS_RESUMING && !wr_c) |=> (res_ack && !resume_flag));

   // R8
   going_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hart_st_valid && hart_st_kind == HS_GOING && !abs_start) |=> !go_flag);

   // R7
   halt_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hart_st_valid && hart_st_kind == HS_HALTED && !go_flag && !abs_start) |=> !abs_busy);

   // R9
   havereset_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_word[S_ALLX] == stat_word[S_ANYX]);

   // R10
   run_halt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(stat_word[S_ALLH] && stat_word[S_ALLR]));
endmodule

bind dbg_regfront dbgfe_chk u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_addr(req_addr), .req_wdata(req_wdata), .hart_st_valid(hart_st_valid),
   .hart_st_kind(hart_st_kind), .abs_start(abs_start), .abs_busy(abs_busy),
   .go_flag(go_flag), .resume_flag(resume_flag), .halt_req(halt_req),
   .xfer_data(xfer_data), .authed(auth_ok), .res_ack(res_ack), .stat_word(stat_w)
);

// File: tb/dbg_regfront_bench.sv
module dbg_regfront_bench;
   localparam int          CLK_P  = 10;
   localparam logic [31:0] SECRET = 32'h5EC2_7A11;
   localparam logic [31:0] SEED   = 32'hACE1_0001;
   localparam logic [6:0]  AD_X = 7'h04, AD_C = 7'h10, AD_S = 7'h11, AD_A = 7'h30;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [6:0]  req_addr = 7'h0;
   logic [31:0] req_wdata = 32'h0;
   logic [31:0] rd_data, n_rd;
   logic        hart_st_valid = 1'b0;
   logic [1:0]  hart_st_kind = 2'd0;
   logic        abs_start = 1'b0;
   logic        abs_busy, go_flag, resume_flag, halt_req, hart_reset, sys_reset, dm_active;
   logic        n_busy, n_go, n_rf, n_halt, n_hr, n_sr, n_act;
   logic [31:0] xfer_data, n_x;
   logic [3:0]  hart_sel, n_hs;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   dbg_regfront #(.SECRET(SECRET), .LFSR_SEED(SEED)) u_dbg_regfront (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
      .hart_st_valid(hart_st_valid), .hart_st_kind(hart_st_kind), .abs_start(abs_start),
      .abs_busy(abs_busy), .go_flag(go_flag), .resume_flag(resume_flag),
      .halt_req(halt_req), .hart_reset(hart_reset), .sys_reset(sys_reset),
      .dm_active(dm_active), .xfer_data(xfer_data), .hart_sel(hart_sel)
   );

   dbg_regfront #(.AUTH_EN(1'b0)) u_noauth (
      .clk(clk), .rst_n(rst_n), .req_valid(1'b0), .req_write(1'b0),
      .req_addr(AD_S), .req_wdata(32'h0), .rd_data(n_rd),
      .hart_st_valid(1'b0), .hart_st_kind(2'd0), .abs_start(1'b0),
      .abs_busy(n_busy), .go_flag(n_go), .resume_flag(n_rf),
      .halt_req(n_halt), .hart_reset(n_hr), .sys_reset(n_sr),
      .dm_active(n_act), .xfer_data(n_x), .hart_sel(n_hs)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd(input logic [6:0] a, output logic [31:0] v);
      req_addr = a;
      #1 v = rd_data;
   endtask

   task automatic hstore(input logic [1:0] k);
      @(negedge clk);
      hart_st_valid = 1'b1; hart_st_kind = k;
      @(negedge clk);
      hart_st_valid = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(AD_C, v); chk("R1 ctrl", v, 32'h0);
      rd(AD_S, v); chk("R1 status", v, 32'h32);
      rd(AD_A, v); chk("R1 challenge", v, SEED);
      chk("R4 noauth status", n_rd, 32'h33);
   endtask

   task automatic t_locked();
      logic [31:0] v;
      wr(AD_X, 32'h1234);
      rd(AD_X, v); chk("R2 data ignored", v, 32'h0);
      wr(AD_C, 32'h103);
      rd(AD_C, v); chk("R2 only active", v, 32'h1);
      chk("R2 halt_req", {31'h0, halt_req}, 32'h0);
   endtask

   task automatic t_auth();
      logic [31:0] c1, c2, v;
      rd(AD_A, c1);
      wr(AD_A, c1 + SECRET + 32'h1);
      rd(AD_S, v);  chk("R3 wrong stays locked", v & 32'h1, 32'h0);
      rd(AD_A, c2); chk("R3 challenge advanced", {31'h0, c2 != c1}, 32'h1);
      wr(AD_A, c2 + SECRET);
      rd(AD_S, v);  chk("R3 unlocked", v, 32'h33);
   endtask

   task automatic t_active_gate();
      logic [31:0] v;
      wr(AD_C, 32'h2);
      rd(AD_C, v); chk("R5 inactive write", v, 32'h0);
      wr(AD_C, 32'h3);
      rd(AD_C, v); chk("R5 active write", v, 32'h3);
      chk("R5 halt_req set", {31'h0, halt_req}, 32'h1);
      wr(AD_C, 32'h2);
      rd(AD_C, v); chk("R5 halt held", v, 32'h2);
      wr(AD_C, 32'h1);
      rd(AD_C, v); chk("R5 halt cleared", v, 32'h1);
   endtask

   task automatic t_data_busy();
      logic [31:0] v;
      wr(AD_X, 32'hCAFE_0001);
      rd(AD_X, v); chk("R13 data stored", v, 32'hCAFE_0001);
      @(negedge clk); abs_start = 1'b1;
      @(negedge clk); abs_start = 1'b0;
      rd(AD_S, v); chk("R8 start sets go+busy", v, 32'h3033);
      wr(AD_X, 32'hBEEF);
      chk("R13 busy write ignored", xfer_data, 32'hCAFE_0001);
      hstore(2'd0);
      rd(AD_S, v); chk("R7 halted, busy held by go", v, 32'h300F);
      hstore(2'd1);
      rd(AD_S, v); chk("R8 going clears go", v, 32'h100F);
      hstore(2'd0);
      rd(AD_S, v); chk("R7 halted clears busy", v, 32'h000F);
   endtask

   task automatic t_resume();
      logic [31:0] v;
      wr(AD_C, 32'h5);
      rd(AD_S, v); chk("R6 resume flag", v, 32'h400F);
      hstore(2'd2);
      rd(AD_S, v); chk("R6 resume ack, R10 running", v, 32'h0333);
   endtask

   task automatic t_havereset();
      logic [31:0] v;
      wr(AD_C, 32'h9);
      rd(AD_S, v); chk("R9 have-reset set", v, 32'h0F33);
      wr(AD_C, 32'h21);
      rd(AD_S, v); chk("R9 have-reset acked", v, 32'h0333);
      rd(AD_C, v); chk("R9 ack not stored", v, 32'h1);
   endtask

   task automatic t_nonexist();
      logic [31:0] v;
      wr(AD_C, 32'h101);
      rd(AD_S, v); chk("R11 nonexistent", v, 32'hC3);
      chk("R11 hart_sel", {28'h0, hart_sel}, 32'h1);
      wr(AD_C, 32'h1);
      rd(AD_S, v); chk("R10 hart0 again", v, 32'h0333);
   endtask

   task automatic t_exception();
      logic [31:0] v;
      hstore(2'd3);
      rd(AD_S, v); chk("R12 exception set", v, 32'h8333);
      wr(AD_C, 32'h1);
      rd(AD_S, v); chk("R12 exception sticky", v, 32'h8333);
      wr(AD_C, 32'h41);
      rd(AD_S, v); chk("R12 exception cleared", v, 32'h0333);
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_locked();
      t_auth();
      t_active_gate();
      t_data_busy();
      t_resume();
      t_havereset();
      t_nonexist();
      t_exception();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule